// File: doc/BRIEF.md
# Coherence Decision Controller

This block judges a vector that an upstream projection stage has reduced to two numbers: the weight that lies in the kernel and the total weight. After a start strobe, it waits for a full recurrence pass of a fixed number of iterations. It then compares the kernel-to-total ratio against two thresholds and picks one of three outcomes:

- **Discard:** a weak vector is dropped with a one-cycle pulse.
- **Retry:** a marginal vector is sent back for another recurrence pass.
- **Lock:** a strong vector is locked.

A locked vector must also show a zero residual before its 192-bit key leaves the block under a valid/ready handshake. A locked vector with a non-zero residual halts the controller until reset.

The ratio tests need no divider. The lower bound is the exact fraction 47/125, and the kernel weight times 125 is compared with the total weight times 47. The upper bound 0.682 is held as the 16-bit fraction 44696/65536 and tested the same way, using wide products. The number of retry passes is capped by a 4-bit limit input.

Top module: `coh_gate`

## Requirements
- R1: After reset the controller is idle. `discard_o`, `retry_o`, `locked_o`, `key_valid_o` and `halt_o` are low, `retries_o` is 0 and `key_o` is all zeros.
- R2: `start_i` is taken only while idle. It clears the retry count and begins a pass. A pass ends only after `DEPTH` (10) cycles with `iter_done_i` high, and no outcome appears before then.
- R3: A total weight of zero, or `kern_w_i*125 < total_w_i*47`, ends in discard. `discard_o` is high for exactly one cycle and the controller returns to idle.
- R4: `kern_w_i*65536 > total_w_i*44696` moves the controller to the locked state, and `locked_o` goes high.
- R5: A ratio at or above the lower bound and not above the upper bound, while `retries_o` is below `retry_lim_i`, asks for another pass. `retry_o` pulses for one cycle, `retries_o` increments, and the iteration count restarts.
- R6: A ratio in that middle band when `retries_o` equals `retry_lim_i` ends in discard, as in R3.
- R7: In the locked state with `resid_zero_i` high, `key_i` is captured and `key_valid_o` rises on the next cycle.
- R8: While `key_valid_o` is high and `key_ready_i` is low, `key_valid_o` stays high and `key_o` holds its value. On a cycle with both high, the transfer completes and the controller goes idle. `key_o` is all zeros whenever `key_valid_o` is low.
- R9: In the locked state with `resid_zero_i` low, `halt_o` rises and stays high until reset. In that case `key_valid_o` stays low and `start_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin evaluation of a new vector |
| iter_done_i | input | 1 | One recurrence iteration finished |
| kern_w_i | input | 16 | Kernel (projected) weight |
| total_w_i | input | 16 | Total weight |
| resid_zero_i | input | 1 | Residual is exactly zero |
| retry_lim_i | input | 4 | Maximum retry passes |
| key_i | input | 192 | Key word captured on release |
| key_ready_i | input | 1 | Sink accepts the key |
| retry_o | output | 1 | One-cycle request for another recurrence pass |
| retries_o | output | 4 | Retry passes taken for the current vector |
| discard_o | output | 1 | One-cycle discard pulse |
| locked_o | output | 1 | Vector locked (residual check or key send pending) |
| key_o | output | 192 | Released key, zero when not valid |
| key_valid_o | output | 1 | Key valid |
| halt_o | output | 1 | Residual check failed, sticky until reset |

## Verification
On every cycle the assertions check the following:
- the discard and retry outputs are single-cycle pulses;
- the four outcome indications are mutually exclusive;
- the key and its valid stay unchanged while the sink stalls;
- a halt persists and never coexists with a valid key;
- a key only appears after a locked state.

The threshold arithmetic can only be shown by the bench's scenarios, which compare each outcome with a model of the two ratio tests. These scenarios also cover the exact boundary values, the retry cap, the ten-iteration wait and the fact that a halted controller ignores new starts.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam int unsigned LO_NUM  = 47;
  localparam int unsigned LO_DEN  = 125;
  localparam int unsigned HI_Q    = 44696;  // 0.682 in Q0.16
  localparam int unsigned HI_FRAC = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ITER,
    ST_EVAL,
    ST_LOCK,
    ST_SEND,
    ST_HALT
  } coh_state_e;

  typedef enum logic [1:0] {
    BAND_LOW,
    BAND_MID,
    BAND_HIGH
  } coh_band_e;
endpackage

// File: rtl/coh_ratio_cmp.sv
module coh_ratio_cmp
  import coh_pkg::*;
#(
  parameter int unsigned WW = 16
) (
  input  logic [WW-1:0] kern_w_i,
  input  logic [WW-1:0] total_w_i,
  output coh_band_e     band_o
);
  localparam int unsigned PW = WW + HI_FRAC + 1;

  logic [PW-1:0] k_lo, t_lo, k_hi, t_hi;
  logic          below_lo, above_hi;

  always_comb begin
    k_lo = PW'(kern_w_i)  * PW'(LO_DEN);
    t_lo = PW'(total_w_i) * PW'(LO_NUM);
    k_hi = PW'(kern_w_i)  << HI_FRAC;
    t_hi = PW'(total_w_i) * PW'(HI_Q);
    below_lo = (total_w_i == '0) || (k_lo < t_lo);
    above_hi = (k_hi > t_hi);
  end

  always_comb begin
    if (below_lo)      band_o = BAND_LOW;
    else if (above_hi) band_o = BAND_HIGH;
    else               band_o = BAND_MID;
  end
endmodule

// File: rtl/coh_iter_cnt.sv
module coh_iter_cnt #(
  parameter int unsigned DEPTH = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic step_i,
  output logic done_o
);
  localparam int unsigned CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (en_i && step_i) begin
      if (cnt_q == LAST)       cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = en_i && step_i && (cnt_q == LAST);
endmodule

// File: rtl/coh_key_hold.sv
module coh_key_hold #(
  parameter int unsigned KW = 192
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [KW-1:0] key_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic          xfer_o,
  output logic [KW-1:0] key_o
);
  logic [KW-1:0] key_q;
  logic          vld_q;

  assign xfer_o = vld_q && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      vld_q <= 1'b0;
    end else if (load_i) begin
      key_q <= key_i;
      vld_q <= 1'b1;
    end else if (xfer_o) begin
      key_q <= '0;
      vld_q <= 1'b0;
    end
  end

  assign valid_o = vld_q;
  assign key_o   = vld_q ? key_q : '0;
endmodule

// File: rtl/coh_gate.sv
module coh_gate
  import coh_pkg::*;
#(
  parameter int unsigned WW    = 16,
  parameter int unsigned KW    = 192,
  parameter int unsigned LW    = 4,
  parameter int unsigned DEPTH = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          iter_done_i,
  input  logic [WW-1:0] kern_w_i,
  input  logic [WW-1:0] total_w_i,
  input  logic          resid_zero_i,
  input  logic [LW-1:0] retry_lim_i,
  input  logic [KW-1:0] key_i,
  input  logic          key_ready_i,
  output logic          retry_o,
  output logic [LW-1:0] retries_o,
  output logic          discard_o,
  output logic          locked_o,
  output logic [KW-1:0] key_o,
  output logic          key_valid_o,
  output logic          halt_o
);
  coh_state_e    st_q, st_d;
  coh_band_e     band;
  logic [LW-1:0] rtry_q;
  logic          pass_done, cnt_clr, key_load, key_xfer;
  logic          disc_d, rtry_d;
  logic          disc_q, rtry_pulse_q;

  coh_ratio_cmp #(.WW(WW)) u_cmp (
    .kern_w_i (kern_w_i),
    .total_w_i(total_w_i),
    .band_o   (band)
  );

  coh_iter_cnt #(.DEPTH(DEPTH)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .en_i  (st_q == ST_ITER),
    .step_i(iter_done_i),
    .done_o(pass_done)
  );

  coh_key_hold #(.KW(KW)) u_key (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (key_load),
    .key_i  (key_i),
    .ready_i(key_ready_i),
    .valid_o(key_valid_o),
    .xfer_o (key_xfer),
    .key_o  (key_o)
  );

  always_comb begin
    st_d     = st_q;
    disc_d   = 1'b0;
    rtry_d   = 1'b0;
    key_load = 1'b0;
    cnt_clr  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d    = ST_ITER;
        cnt_clr = 1'b1;
      end
      ST_ITER: if (pass_done) st_d = ST_EVAL;
      ST_EVAL: begin
        unique case (band)
          BAND_HIGH: st_d = ST_LOCK;
          BAND_MID: begin
            if (rtry_q != retry_lim_i) begin
              rtry_d  = 1'b1;
              cnt_clr = 1'b1;
              st_d    = ST_ITER;
            end else begin
              disc_d = 1'b1;
              st_d   = ST_IDLE;
            end
          end
          default: begin
            disc_d = 1'b1;
            st_d   = ST_IDLE;
          end
        endcase
      end
      ST_LOCK: begin
        if (resid_zero_i) begin
          key_load = 1'b1;
          st_d     = ST_SEND;
        end else begin
          st_d = ST_HALT;
        end
      end
      ST_SEND: if (key_xfer) st_d = ST_IDLE;
      ST_HALT: st_d = ST_HALT;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      rtry_q       <= '0;
      disc_q       <= 1'b0;
      rtry_pulse_q <= 1'b0;
    end else begin
      st_q         <= st_d;
      disc_q       <= disc_d;
      rtry_pulse_q <= rtry_d;
      if (st_q == ST_IDLE && start_i) rtry_q <= '0;
      else if (rtry_d)                rtry_q <= rtry_q + 1'b1;
    end
  end

  assign retry_o   = rtry_pulse_q;
  assign retries_o = rtry_q;
  assign discard_o = disc_q;
  assign locked_o  = (st_q == ST_LOCK) || (st_q == ST_SEND);
  assign halt_o    = (st_q == ST_HALT);
endmodule

// File: rtl/coh_gate_chk.sv
module coh_gate_chk #(
  parameter int unsigned KW = 192,
  parameter int unsigned LW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          retry_o,
  input logic [LW-1:0] retries_o,
  input logic          discard_o,
  input logic          locked_o,
  input logic [KW-1:0] key_o,
  input logic          key_valid_o,
  input logic          key_ready_i,
  input logic          halt_o
);
  AST_DISCARD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |=> !discard_o); // R3
  AST_RETRY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |=> !retry_o); // R5
  AST_RETRY_COUNTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> retries_o != '0); // R5
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({discard_o, retry_o, key_valid_o, halt_o})); // R4
  AST_KEY_AFTER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(key_valid_o) |-> $past(locked_o)); // R7
  AST_KEY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_valid_o && !key_ready_i) |=> (key_valid_o && $stable(key_o))); // R8
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o); // R9
  AST_HALT_NO_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !key_valid_o); // R9
endmodule

bind coh_gate coh_gate_chk #(.KW(KW), .LW(LW)) u_chk (.*);

// File: tb/coh_gate_test.sv
module coh_gate_test;
  localparam int WW = 16, KW = 192, LW = 4, DEPTH = 10;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0, iter_done_i = 1'b0, resid_zero_i = 1'b0, key_ready_i = 1'b0;
  logic [WW-1:0] kern_w_i = '0, total_w_i = '0;
  logic [LW-1:0] retry_lim_i = '0;
  logic [KW-1:0] key_i = '0;
  logic          retry_o, discard_o, locked_o, key_valid_o, halt_o;
  logic [LW-1:0] retries_o;
  logic [KW-1:0] key_o;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  coh_gate #(.WW(WW), .KW(KW), .LW(LW), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .iter_done_i(iter_done_i),
    .kern_w_i(kern_w_i), .total_w_i(total_w_i), .resid_zero_i(resid_zero_i),
    .retry_lim_i(retry_lim_i), .key_i(key_i), .key_ready_i(key_ready_i),
    .retry_o(retry_o), .retries_o(retries_o), .discard_o(discard_o),
    .locked_o(locked_o), .key_o(key_o), .key_valid_o(key_valid_o), .halt_o(halt_o)
  );

  // 0 low, 1 mid, 2 high
  function automatic int band_of(int unsigned k, int unsigned t);
    longint unsigned kk = k, tt = t;
    if (tt == 0 || kk * 125 < tt * 47) return 0;
    if (kk * 65536 > tt * 44696) return 2;
    return 1;
  endfunction

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    start_i = 0; iter_done_i = 0; key_ready_i = 0;
    @(negedge clk); @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // returns 0 discard, 1 retry, 2 key valid, 3 halt, 4 none
  task automatic wait_outcome(output int oc);
    oc = 4;
    for (int c = 0; c < 6 && oc == 4; c++) begin
      @(negedge clk);
      if (discard_o)        oc = 0;
      else if (retry_o)     oc = 1;
      else if (key_valid_o) oc = 2;
      else if (halt_o)      oc = 3;
    end
  endtask

  task automatic run_pass(bit check_early);
    iter_done_i = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      if (check_early && i == DEPTH - 1)
        chk("R2 early outcome", {discard_o, retry_o, locked_o, key_valid_o}, 4'b0);
    end
    iter_done_i = 1'b0;
  endtask

  task automatic run_vec(int unsigned k, int unsigned t, bit rz, int lim, logic [KW-1:0] key);
    int b, oc, exp_oc;
    kern_w_i = WW'(k); total_w_i = WW'(t); resid_zero_i = rz;
    retry_lim_i = LW'(lim); key_i = key;
    b = band_of(k, t);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    for (int p = 0; p <= lim; p++) begin
      run_pass(p == 0);
      wait_outcome(oc);
      if (b == 0)                  exp_oc = 0;
      else if (b == 2)             exp_oc = rz ? 2 : 3;
      else if (p < lim)            exp_oc = 1;
      else                         exp_oc = 0;
      if (b == 0)      chk("R3 low band", oc, exp_oc);
      else if (b == 2) chk(rz ? "R7 release" : "R9 halt", oc, exp_oc);
      else if (p < lim) chk("R5 retry", oc, exp_oc);
      else             chk("R6 retry cap", oc, exp_oc);
      if (oc == 1) begin
        chk("R5 retries count", retries_o, p + 1);
        @(negedge clk);
        chk("R5 retry pulse width", retry_o, 0);
        continue;
      end
      if (oc == 0) begin
        @(negedge clk);
        chk("R3 discard pulse width", discard_o, 0);
      end
      if (oc == 2) begin
        chk("R4 locked", locked_o, 1);
        chk("R7 key value", key_o, key);
        key_i = ~key;
        @(negedge clk); @(negedge clk);
        chk("R8 hold valid", key_valid_o, 1);
        chk("R8 hold key", key_o, key);
        key_ready_i = 1'b1; @(negedge clk); key_ready_i = 1'b0;
        chk("R8 released", key_valid_o, 0);
        chk("R8 key gated", key_o, '0);
      end
      if (oc == 3) begin
        chk("R9 no key", key_valid_o, 0);
        do_reset();
      end
      break;
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    report();
  end

  initial begin
    logic [KW-1:0] kv;
    int oc;
    void'($urandom(32'd1234));
    do_reset();
    chk("R1 reset outputs", {discard_o, retry_o, locked_o, key_valid_o, halt_o}, 5'b0);
    chk("R1 reset retries", retries_o, 0);
    chk("R1 reset key", key_o, '0);

    kv = {6{32'hC0FFEE01}};
    run_vec(46, 125, 1, 2, kv);       // just below 47/125
    run_vec(47, 125, 1, 0, kv);       // exactly at lower bound -> mid, cap 0
    run_vec(47, 125, 1, 3, kv);       // retries then cap
    run_vec(0, 0, 1, 2, kv);          // zero total
    run_vec(5587, 8192, 1, 1, kv);    // exactly 0.682 fraction -> mid
    run_vec(5588, 8192, 1, 1, kv);    // above upper -> lock, release
    run_vec(65535, 65535, 1, 1, {6{32'h5A5AA5A5}});

    // start ignored while a pass is running (R2)
    kern_w_i = 16'd900; total_w_i = 16'd1000; resid_zero_i = 1; retry_lim_i = 0;
    start_i = 1; @(negedge clk); start_i = 0;
    iter_done_i = 1; repeat (5) @(negedge clk);
    start_i = 1; @(negedge clk); start_i = 0;
    repeat (4) @(negedge clk); iter_done_i = 0;
    wait_outcome(oc);
    chk("R2 restart ignored", oc, 2);
    key_ready_i = 1; @(negedge clk); key_ready_i = 0;

    // halt, then start has no effect (R9)
    kern_w_i = 16'd900; total_w_i = 16'd1000; resid_zero_i = 0;
    start_i = 1; @(negedge clk); start_i = 0;
    run_pass(0);
    wait_outcome(oc);
    chk("R9 halt entered", oc, 3);
    resid_zero_i = 1; start_i = 1; @(negedge clk); start_i = 0;
    run_pass(0);
    repeat (3) @(negedge clk);
    chk("R9 halt sticky", {halt_o, key_valid_o}, 2'b10);
    do_reset();

    for (int n = 0; n < 60; n++) begin
      int unsigned t, k;
      t = ($urandom % 65535) + 1;
      k = (n % 7 == 0) ? ($urandom % 65536) : ($urandom % (t + 1));
      if (n % 5 == 0) k = (t * 47 + 124) / 125 + ($urandom % 3);
      run_vec(k, t, ($urandom % 4) != 0, $urandom % 4, {6{$urandom}});
    end
    report();
  end
endmodule